// File: doc/BRIEF.md
# High-Speed Clock Loss Monitor

This block checks that a high-speed system clock keeps toggling. It runs entirely on an always-on internal oscillator clock. The monitored clock is brought into that domain through a two-flop synchronizer, and its rising edges are detected there. A watchdog counter restarts on every detected edge. If the counter runs out while monitoring is active, the block raises a one-cycle fault request that the reset logic of the chip can act on.

Monitoring is switched on by a write-once enable bit and is gated by a small power/oscillator state machine. The machine suspends monitoring in three cases: during standby, while software holds the oscillator off, and while the oscillator is settling after it restarts. Monitoring resumes by itself once settling ends, with no software action. The settling interval is counted in synchronized high-speed clock edges, and its length is picked by a 3-bit select. Two separate software stop bits exist. The one that counts is chosen by the clock source currently feeding the processor.

The monitored clock must toggle at no more than half the internal oscillator rate as seen by the synchronizer. In practice that means a prescaled tap of the high-speed clock.

Top module: `hs_clock_monitor`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `mon_active` and `fault_req` are 0 and the enable bit is cleared. Reset places the state machine in the settling state.
- R2: A cycle with `en_wr`=1 and `en_data`=1 sets the enable bit. A write with `en_data`=0 never clears it; only reset does.
- R3: `mon_active` is 1 exactly when the enable bit is set and the machine is in the running state. A `stop_req` pulse while running drops `mon_active` on the next cycle.
- R4: In standby no fault is raised, even when the monitored clock is dead.
- R5: After `wake`, monitoring stays off until 2^(2+`stab_sel`) synchronized rising edges of the monitored clock have been counted. It then turns on by itself. For example, `stab_sel`=3 needs 32 edges.
- R6: The effective oscillator stop is `osc_stop_int` when `cpu_src`=0 and `osc_stop_sub` when `cpu_src`=1. While it is 1, monitoring is off. When it returns to 0, monitoring resumes after the settling interval of R5.
- R7: The stop bit that `cpu_src` does not select has no effect on `mon_active`.
- R8: If the enable bit is written while the oscillator is stopped, monitoring starts only at the end of the settling interval that follows the restart.
- R9: While monitoring is active, 16 consecutive internal clock cycles with no synchronized rising edge produce a `fault_req` pulse one cycle wide. The pulse repeats every further 16 cycles for as long as the clock stays dead.
- R10: With the enable bit clear, a dead monitored clock raises no fault.
- R11: When `stop_req` and the effective oscillator stop arrive in the same running cycle, standby wins. A later `wake` with the oscillator still stopped leads to the oscillator-off state, and monitoring stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_clk | input | 1 | Monitored high-speed clock (sampled as data) |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_data | input | 1 | Value written to the enable bit |
| stop_req | input | 1 | Request to enter standby |
| wake | input | 1 | Wake event leaving standby |
| cpu_src | input | 1 | Processor clock source: 0 internal, 1 subsystem |
| osc_stop_int | input | 1 | Software oscillator stop used when cpu_src=0 |
| osc_stop_sub | input | 1 | Software oscillator stop used when cpu_src=1 |
| stab_sel | input | 3 | Settling interval select |
| mon_active | output | 1 | Monitoring is active |
| fault_req | output | 1 | One-cycle clock-loss fault request |

## Verification
Two functions can collide in one running cycle: entry into standby and a software oscillator stop. The bench provokes this by raising `stop_req` and `osc_stop_int` on the same clock edge while monitoring is active. It then judges the outcome by the path the machine takes. Monitoring must drop at once, must stay off through a `wake` that arrives while the oscillator is still stopped, and must return only after a full settling interval once the stop is released. A scoreboard also compares running fault counts at every checkpoint, so a fault that slips through during the collision shows up as a count mismatch.

// File: rtl/clkmon_pkg.sv
// Package: shared types for the high-speed clock loss monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package clkmon_pkg;

    // Power/oscillator state of the monitored clock.
    typedef enum logic [1:0] {
        ST_STAB    = 2'd0,  // oscillator settling, monitoring off
        ST_RUN     = 2'd1,  // oscillator stable, monitoring allowed
        ST_STANDBY = 2'd2,  // device in standby, monitoring off
        ST_OSC_OFF = 2'd3   // oscillator stopped by software
    } mon_state_e;

endpackage

// File: rtl/clkmon_edge_sync.sv
// Module: clkmon_edge_sync
// Brings the monitored clock into the internal oscillator domain through a
// STAGES-deep flop chain and flags each rising edge for one cycle.
// Assumes: the monitored signal toggles no faster than half of clk.
module clkmon_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES:0] chain_q;

    // Shift the raw input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_i};
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/clkmon_ctrl.sv
// Module: clkmon_ctrl
// Write-once enable bit, the power/oscillator state machine and the
// settling counter. The settling counter counts synchronized edges of the
// monitored clock and ends at 2^(STAB_BASE + sel).
// Assumes: stop_i takes priority over the oscillator stop in every state.
module clkmon_ctrl
    import clkmon_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int STAB_BASE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr_i,
    input  logic             en_data_i,
    input  logic             stop_i,
    input  logic             wake_i,
    input  logic             cpu_src_i,
    input  logic             osc_stop_int_i,
    input  logic             osc_stop_sub_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             edge_i,
    output logic             active_o
);

    localparam int STAB_W = STAB_BASE + (1 << SEL_W) + 1;

    mon_state_e        state_q, state_d;
    logic              en_q;
    logic              osc_off;
    logic [STAB_W-1:0] stab_cnt_q;
    logic [STAB_W-1:0] stab_tc;
    logic              stab_last;

    // Pick the software stop bit that belongs to the current CPU clock source.
    always_comb osc_off = cpu_src_i ? osc_stop_sub_i : osc_stop_int_i;

    // Terminal count of the settling interval from the select value.
    always_comb begin
        stab_tc   = STAB_W'(1) << (STAB_W'(STAB_BASE) + STAB_W'(sel_i));
        stab_last = (stab_cnt_q == stab_tc - STAB_W'(1));
    end

    // Enable bit: set by a write of one, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_wr_i && en_data_i) begin
            en_q <= 1'b1;
        end
    end

    // Next-state decision of the power/oscillator machine.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN: begin
                if (stop_i)       state_d = ST_STANDBY;
                else if (osc_off) state_d = ST_OSC_OFF;
            end
            ST_STANDBY: begin
                if (wake_i)       state_d = ST_STAB;
            end
            ST_OSC_OFF: begin
                if (stop_i)       state_d = ST_STANDBY;
                else if (!osc_off) state_d = ST_STAB;
            end
            ST_STAB: begin
                if (stop_i)                  state_d = ST_STANDBY;
                else if (osc_off)            state_d = ST_OSC_OFF;
                else if (edge_i && stab_last) state_d = ST_RUN;
            end
            default: state_d = ST_STAB;
        endcase
    end

    // State register; reset assumes the oscillator is just starting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STAB;
        end else begin
            state_q <= state_d;
        end
    end

    // Settling counter: counts edges only while settling continues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stab_cnt_q <= '0;
        end else if (state_q != ST_STAB || state_d != ST_STAB) begin
            stab_cnt_q <= '0;
        end else if (edge_i) begin
            stab_cnt_q <= stab_cnt_q + STAB_W'(1);
        end
    end

    assign active_o = en_q && (state_q == ST_RUN);

    // R2
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> en_q);

    // R3
    stop_drops_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_i) |=> !active_o);

    // R5
    run_only_after_stab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(state_q) == ST_STAB);

    // R6
    osc_off_blocks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_off && state_q != ST_STANDBY) |=> state_q != ST_RUN);

    // R11
    standby_blocks_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY) |=> state_q != ST_RUN);

endmodule

// File: rtl/clkmon_detect.sv
// Module: clkmon_detect
// Loss detector: a counter on the internal clock restarts on each detected
// edge of the monitored clock and raises a one-cycle fault after LIMIT idle
// cycles while monitoring is active. It then restarts to repeat the fault.
// Assumes: LIMIT is at least 2.
module clkmon_detect #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic edge_i,
    output logic fault_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] idle_q;

    // Count idle cycles and flag the terminal one as a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q  <= '0;
            fault_o <= 1'b0;
        end else begin
            fault_o <= 1'b0;
            if (!active_i || edge_i) begin
                idle_q <= '0;
            end else if (idle_q == CNT_W'(LIMIT - 1)) begin
                idle_q  <= '0;
                fault_o <= 1'b1;
            end else begin
                idle_q <= idle_q + CNT_W'(1);
            end
        end
    end

    // R9
    fault_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);

    // R10
    fault_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(active_i));

endmodule

// File: rtl/hs_clock_monitor.sv
// Module: hs_clock_monitor (top)
// Ties together the synchronizer, the control machine and the detector.
// Assumes: hs_clk toggles no faster than half of clk; reset is synchronous.
module hs_clock_monitor #(
    parameter int SEL_W     = 3,
    parameter int STAB_BASE = 2,
    parameter int LIMIT     = 16,
    parameter int SYNC_LEN  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_clk,
    input  logic             en_wr,
    input  logic             en_data,
    input  logic             stop_req,
    input  logic             wake,
    input  logic             cpu_src,
    input  logic             osc_stop_int,
    input  logic             osc_stop_sub,
    input  logic [SEL_W-1:0] stab_sel,
    output logic             mon_active,
    output logic             fault_req
);

    logic hs_rise;

    clkmon_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (hs_clk),
        .rise_o  (hs_rise)
    );

    clkmon_ctrl #(.SEL_W(SEL_W), .STAB_BASE(STAB_BASE)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_wr_i        (en_wr),
        .en_data_i      (en_data),
        .stop_i         (stop_req),
        .wake_i         (wake),
        .cpu_src_i      (cpu_src),
        .osc_stop_int_i (osc_stop_int),
        .osc_stop_sub_i (osc_stop_sub),
        .sel_i          (stab_sel),
        .edge_i         (hs_rise),
        .active_o       (mon_active)
    );

    clkmon_detect #(.LIMIT(LIMIT)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (mon_active),
        .edge_i   (hs_rise),
        .fault_o  (fault_req)
    );

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (!mon_active && !fault_req));

endmodule

// File: tb/hs_clock_monitor_tb.sv
`timescale 1ns/1ps
module hs_clock_monitor_tb;

    typedef struct {
        string req;
        logic  act;
        int    flt;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_clk = 1'b0;
    logic       hs_run = 1'b1;
    logic       en_wr = 1'b0;
    logic       en_data = 1'b0;
    logic       stop_req = 1'b0;
    logic       wake = 1'b0;
    logic       cpu_src = 1'b0;
    logic       osc_stop_int = 1'b0;
    logic       osc_stop_sub = 1'b0;
    logic [2:0] stab_sel = 3'd0;
    logic       mon_active;
    logic       fault_req;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    int   fault_cnt = 0;
    bit   done = 1'b0;

    hs_clock_monitor u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hs_clk       (hs_clk),
        .en_wr        (en_wr),
        .en_data      (en_data),
        .stop_req     (stop_req),
        .wake         (wake),
        .cpu_src      (cpu_src),
        .osc_stop_int (osc_stop_int),
        .osc_stop_sub (osc_stop_sub),
        .stab_sel     (stab_sel),
        .mon_active   (mon_active),
        .fault_req    (fault_req)
    );

    // 50 MHz internal clock.
    always #10 clk = ~clk;

    // Monitored clock: period 80 ns while running, held low when dead.
    initial forever begin
        #40;
        if (hs_run) hs_clk = ~hs_clk;
        else        hs_clk = 1'b0;
    end

    // Count fault pulses away from the active edge.
    always @(negedge clk) if (fault_req === 1'b1) fault_cnt++;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side of the scoreboard: queue an expectation for now.
    task automatic expect_now(input string req, input logic act, input int flt);
        exp_t e;
        e.req = req; e.act = act; e.flt = flt;
        q.push_back(e);
    endtask

    task automatic pulse_stop();
        stop_req = 1'b1; step(1); stop_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake = 1'b1; step(1); wake = 1'b0;
    endtask

    task automatic write_en(input logic v);
        en_wr = 1'b1; en_data = v; step(1); en_wr = 1'b0; en_data = 1'b0;
    endtask

    // Monitor side of the scoreboard: pop and compare.
    initial begin
        exp_t e;
        forever begin
            wait (q.size() > 0);
            #2;
            e = q.pop_front();
            total++;
            if (mon_active !== e.act || fault_cnt != e.flt) begin
                bad++;
                $display("FAIL %s: mon_active=%0b faults=%0d expected mon_active=%0b faults=%0d",
                         e.req, mon_active, fault_cnt, e.act, e.flt);
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        expect_now("R1 during reset", 1'b0, 0);
        rst_n = 1'b1;
        step(1);
        expect_now("R1 after reset", 1'b0, 0);
        step(40);
        expect_now("R10 settled, enable clear", 1'b0, 0);
        hs_run = 1'b0;
        step(60);
        expect_now("R10 dead clock, no enable", 1'b0, 0);
        hs_run = 1'b1;
        step(10);

        write_en(1'b1);
        step(1);
        expect_now("R2 enable set", 1'b1, 0);
        write_en(1'b0);
        step(2);
        expect_now("R2 zero write ignored", 1'b1, 0);

        hs_run = 1'b0;
        step(28);
        expect_now("R9 first fault", 1'b1, 1);
        step(12);
        expect_now("R9 repeated fault", 1'b1, 2);
        hs_run = 1'b1;
        step(10);
        expect_now("R9 clock back, no more faults", 1'b1, 2);

        pulse_stop();
        hs_run = 1'b0;
        expect_now("R3 stop drops active", 1'b0, 2);
        step(60);
        expect_now("R4 standby no fault", 1'b0, 2);

        stab_sel = 3'd3;
        hs_run = 1'b1;
        pulse_wake();
        step(109);
        expect_now("R5 still settling", 1'b0, 2);
        step(40);
        expect_now("R5 resumed after settling", 1'b1, 2);

        osc_stop_sub = 1'b1;
        step(5);
        expect_now("R7 unselected stop ignored", 1'b1, 2);
        osc_stop_sub = 1'b0;

        stab_sel = 3'd0;
        osc_stop_int = 1'b1;
        hs_run = 1'b0;
        step(2);
        expect_now("R6 internal-source stop", 1'b0, 2);
        step(40);
        expect_now("R6 stays off while stopped", 1'b0, 2);
        osc_stop_int = 1'b0;
        hs_run = 1'b1;
        step(8);
        expect_now("R6 settling after restart", 1'b0, 2);
        step(30);
        expect_now("R6 resumed", 1'b1, 2);

        cpu_src = 1'b1;
        osc_stop_sub = 1'b1;
        hs_run = 1'b0;
        step(2);
        expect_now("R6 subsystem-source stop", 1'b0, 2);
        osc_stop_sub = 1'b0;
        hs_run = 1'b1;
        step(40);
        expect_now("R6 subsystem restart resumed", 1'b1, 2);
        cpu_src = 1'b0;

        rst_n = 1'b0;
        step(3);
        expect_now("R1 second reset clears enable", 1'b0, 2);
        rst_n = 1'b1;
        osc_stop_int = 1'b1;
        hs_run = 1'b0;
        step(3);
        write_en(1'b1);
        step(20);
        expect_now("R8 enable while stopped", 1'b0, 2);
        osc_stop_int = 1'b0;
        hs_run = 1'b1;
        step(8);
        expect_now("R8 waits for settling", 1'b0, 2);
        step(30);
        expect_now("R8 begins after settling", 1'b1, 2);

        stop_req = 1'b1;
        osc_stop_int = 1'b1;
        step(1);
        stop_req = 1'b0;
        hs_run = 1'b0;
        step(1);
        expect_now("R11 collision drops active", 1'b0, 2);
        pulse_wake();
        step(60);
        expect_now("R11 wake with osc stopped", 1'b0, 2);
        osc_stop_int = 1'b0;
        hs_run = 1'b1;
        step(40);
        expect_now("R11 resumed after release", 1'b1, 2);

        step(3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule